// File: doc/BRIEF.md
# Adaptive Min/Max Threshold Slicer

This block turns a stream of unsigned ADC samples into a logic-level bit stream when neither the ambient offset nor the signal amplitude is known in advance and both drift over time. It keeps two trackers in fixed point. A peak tracker jumps up to any sample above it and otherwise sinks slowly toward the samples. A floor tracker mirrors it from below. The decision level is the midpoint of the two, so it follows both the background level and the swing of the signal.

A sample is sliced against that midpoint with a hysteresis band one eighth of the tracked swing wide on each side. The output bit only changes when a sample lands beyond the far edge of the band. A settled flag reports that the tracked swing has stayed above a programmable minimum for a run of consecutive samples. The stream feeding the block is expected to be DC-balanced and to open with a preamble of comma symbols, which gives the trackers time to settle. A synchronous clear restarts tracking between transmissions.

Top module: `adaptive_slicer`

## Requirements
- R1: After reset, `threshold` is 128, `bit_out` is 0 and `settled` is 0. Both trackers start at mid-scale, which is 2048 in the 12-bit fixed-point form (8 integer bits and 4 fractional bits).
- R2: On a valid sample whose fixed-point value (the sample shifted left by 4) is above the peak tracker, the peak tracker takes that value. If the sample is below the floor tracker, the floor tracker takes it.
- R3: On a valid sample at or below the peak tracker, the peak tracker drops by (peak − sample) >> 3. This lets an isolated high sample after a long low run still slice as 1.
- R4: On a valid sample at or above the floor tracker, the floor tracker rises by (sample − floor) >> 3.
- R5: `threshold` equals (peak + floor) >> 5, which is the integer part of the trackers' midpoint. The floor tracker never exceeds the peak tracker.
- R6: Let S be the fixed-point sample, P+F the sum of the trackers, and H = (P − F) >> 3, all taken before the sample's update. The output goes to 1 when 2S > P+F + 2H, goes to 0 when 2S + 2H < P+F, and otherwise holds its value.
- R7: A cycle with `smp_valid` low changes neither the trackers nor any output.
- R8: A valid sample counts toward settling when P − F (before update) exceeds `min_swing` << 4. Any valid sample that does not meet this resets the count. `settled` rises at the clock edge of the 16th consecutive counting sample.
- R9: Once set, `settled` stays high until `rst` or `clear`.
- R10: `clear` high at a clock edge restores the reset state of R1, whatever `smp_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous restart of tracking |
| smp_valid | input | 1 | Marks `smp_data` as a new sample |
| smp_data | input | 8 | Unsigned ADC sample |
| min_swing | input | 8 | Minimum peak-to-floor swing for settling, in sample units |
| bit_out | output | 1 | Sliced logic level |
| threshold | output | 8 | Integer part of the decision midpoint |
| settled | output | 1 | Swing has held above the minimum for the required run |

## Verification
The bench builds the block with its default parameters: 8-bit samples, 4 fractional bits, a decay and hysteresis shift of 3, and a settle run of 16. With a shift of 3 the trackers converge within a few dozen samples, so tracker decay, isolated ones after long low runs, and settling all fit inside short runs of random multi-level bursts. The bench drives `min_swing` at 0, 20, 40 and 255. This covers a flag that settles at once, one that settles after a delay, and one that never settles. It also drives clears in the middle of a stream and idle gaps carrying junk data.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  typedef enum logic {TRK_PEAK = 1'b0, TRK_FLOOR = 1'b1} trk_kind_e;
endpackage

// File: rtl/slicer_tracker.sv
module slicer_tracker
  import slicer_pkg::*;
#(
  parameter int        ACC_W = 12,
  parameter int        SHIFT = 3,
  parameter trk_kind_e KIND  = TRK_PEAK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             valid,
  input  logic [ACC_W-1:0] sample,
  output logic [ACC_W-1:0] level
);
  localparam logic [ACC_W-1:0] MID = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] level_nx;

  generate
    if (KIND == TRK_PEAK) begin : g_peak
      always_comb begin
        if (sample > level) level_nx = sample;
        else                level_nx = level - ((level - sample) >> SHIFT);
      end
    end else begin : g_floor
      always_comb begin
        if (sample < level) level_nx = sample;
        else                level_nx = level + ((sample - level) >> SHIFT);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear)  level <= MID;
    else if (valid)    level <= level_nx;
  end
endmodule

// File: rtl/slicer_decider.sv
module slicer_decider #(
  parameter int ACC_W  = 12,
  parameter int FRAC_W = 4,
  parameter int HYST_SHIFT = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    valid,
  input  logic [ACC_W-1:0]        sample,
  input  logic [ACC_W-1:0]        peak,
  input  logic [ACC_W-1:0]        floor_lvl,
  output logic [ACC_W-1:0]        swing,
  output logic [ACC_W-FRAC_W-1:0] thr_int,
  output logic                    bit_q
);
  localparam int XW = ACC_W + 2;

  logic [ACC_W:0]   pair_sum;
  logic [ACC_W-1:0] hyst;
  logic [XW-1:0]    s2, h2, sum2;
  logic             go_high, go_low;

  always_comb begin
    pair_sum = {1'b0, peak} + {1'b0, floor_lvl};
    swing    = peak - floor_lvl;
    hyst     = swing >> HYST_SHIFT;
    s2       = {1'b0, sample, 1'b0};
    h2       = {1'b0, hyst, 1'b0};
    sum2     = {1'b0, pair_sum};
    go_high  = s2 > (sum2 + h2);
    go_low   = (s2 + h2) < sum2;
    thr_int  = pair_sum[ACC_W:FRAC_W+1];
  end

  always_ff @(posedge clk) begin
    if (rst || clear)       bit_q <= 1'b0;
    else if (valid) begin
      if (go_high)          bit_q <= 1'b1;
      else if (go_low)      bit_q <= 1'b0;
    end
  end
endmodule

// File: rtl/slicer_settle.sv
module slicer_settle #(
  parameter int ACC_W      = 12,
  parameter int FRAC_W     = 4,
  parameter int SETTLE_LEN = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    valid,
  input  logic [ACC_W-1:0]        swing,
  input  logic [ACC_W-FRAC_W-1:0] min_swing,
  output logic                    settled
);
  localparam int CW = $clog2(SETTLE_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_LEN - 1);
  localparam logic [CW-1:0] FULL = CW'(SETTLE_LEN);

  logic [CW-1:0] run_cnt;
  logic          wide;

  assign wide = swing > {min_swing, {FRAC_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_cnt <= '0;
      settled <= 1'b0;
    end else if (valid) begin
      if (wide) begin
        if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
        if (run_cnt == LAST) settled <= 1'b1;
      end else begin
        run_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/adaptive_slicer.sv
module adaptive_slicer
  import slicer_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int FRAC_W      = 4,
  parameter int DECAY_SHIFT = 3,
  parameter int HYST_SHIFT  = 3,
  parameter int SETTLE_LEN  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [SAMPLE_W-1:0] min_swing,
  output logic                bit_out,
  output logic [SAMPLE_W-1:0] threshold,
  output logic                settled
);
  localparam int ACC_W = SAMPLE_W + FRAC_W;

  logic [ACC_W-1:0] sample_fx, peak_lvl, floor_lvl, swing;

  assign sample_fx = {smp_data, {FRAC_W{1'b0}}};

  slicer_tracker #(.ACC_W(ACC_W), .SHIFT(DECAY_SHIFT), .KIND(TRK_PEAK)) u_peak (
    .clk(clk), .rst(rst), .clear(clear), .valid(smp_valid),
    .sample(sample_fx), .level(peak_lvl));

  slicer_tracker #(.ACC_W(ACC_W), .SHIFT(DECAY_SHIFT), .KIND(TRK_FLOOR)) u_floor (
    .clk(clk), .rst(rst), .clear(clear), .valid(smp_valid),
    .sample(sample_fx), .level(floor_lvl));

  slicer_decider #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .HYST_SHIFT(HYST_SHIFT)) u_dec (
    .clk(clk), .rst(rst), .clear(clear), .valid(smp_valid),
    .sample(sample_fx), .peak(peak_lvl), .floor_lvl(floor_lvl),
    .swing(swing), .thr_int(threshold), .bit_q(bit_out));

  slicer_settle #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .SETTLE_LEN(SETTLE_LEN)) u_settle (
    .clk(clk), .rst(rst), .clear(clear), .valid(smp_valid),
    .swing(swing), .min_swing(min_swing), .settled(settled));
endmodule

// File: rtl/slicer_checker.sv
module slicer_checker #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                clear,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic                bit_out,
  input logic [SAMPLE_W-1:0] threshold,
  input logic                settled,
  input logic [ACC_W-1:0]    peak_lvl,
  input logic [ACC_W-1:0]    floor_lvl
);
  a_r5_floor_below_peak: assert property (@(posedge clk) disable iff (rst)
    floor_lvl <= peak_lvl);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !clear) |=> ($stable(threshold) && $stable(bit_out) && $stable(settled)));

  a_r10_clear_restores: assert property (@(posedge clk) disable iff (rst)
    clear |=> (threshold == (SAMPLE_W'(1) << (SAMPLE_W - 1)) && !bit_out && !settled));

  a_r9_settled_sticky: assert property (@(posedge clk) disable iff (rst)
    (settled && !clear) |=> settled);

  a_r6_rise_above: assert property (@(posedge clk) disable iff (rst)
    $rose(bit_out) |-> ($past(smp_valid) && $past(smp_data) > $past(threshold)));

  a_r6_fall_below: assert property (@(posedge clk) disable iff (rst)
    $fell(bit_out) |-> ($past(clear) || $past(smp_data) <= $past(threshold)));
endmodule

bind adaptive_slicer slicer_checker #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .clear(clear), .smp_valid(smp_valid), .smp_data(smp_data),
  .bit_out(bit_out), .threshold(threshold), .settled(settled),
  .peak_lvl(peak_lvl), .floor_lvl(floor_lvl));

// File: tb/adaptive_slicer_bench.sv
module adaptive_slicer_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, clear, smp_valid;
  logic [7:0] smp_data, min_swing;
  logic       bit_out, settled;
  logic [7:0] threshold;

  int  n_cmp = 0, n_bad = 0;
  bit  finished = 1'b0;
  int  m_pk, m_fl, m_cnt;
  bit  m_bit, m_set;

  always #(CLK_PERIOD/2) clk = ~clk;

  adaptive_slicer u_adaptive_slicer (
    .clk(clk), .rst(rst), .clear(clear), .smp_valid(smp_valid),
    .smp_data(smp_data), .min_swing(min_swing), .bit_out(bit_out),
    .threshold(threshold), .settled(settled));

  function automatic int clamp8(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  task automatic model_reset();
    m_pk = 2048; m_fl = 2048; m_cnt = 0; m_bit = 1'b0; m_set = 1'b0;
  endtask

  task automatic model_step(bit v, int d, bit clr);
    int s, sw, h, sum;
    if (clr) begin
      model_reset();
    end else if (v) begin
      s = d * 16; sw = m_pk - m_fl; h = sw / 8; sum = m_pk + m_fl;
      if (2*s > sum + 2*h)      m_bit = 1'b1;
      else if (2*s + 2*h < sum) m_bit = 1'b0;
      if (sw > min_swing * 16) begin
        if (m_cnt == 15) m_set = 1'b1;
        if (m_cnt != 16) m_cnt++;
      end else m_cnt = 0;
      if (s > m_pk) m_pk = s; else m_pk = m_pk - ((m_pk - s) >> 3);
      if (s < m_fl) m_fl = s; else m_fl = m_fl + ((s - m_fl) >> 3);
    end
  endtask

  task automatic check(string tag);
    int exp_thr;
    exp_thr = (m_pk + m_fl) >> 5;
    n_cmp++;
    if (bit_out !== m_bit || threshold !== exp_thr[7:0] || settled !== m_set) begin
      n_bad++;
      $display("FAIL %s: bit=%0d exp %0d, threshold=%0d exp %0d, settled=%0d exp %0d",
               tag, bit_out, m_bit, threshold, exp_thr, settled, m_set);
    end
  endtask

  task automatic cyc(bit v, int d, bit clr, string tag);
    smp_valid = v; smp_data = d[7:0]; clear = clr;
    model_step(v, d, clr);
    @(negedge clk);
    check(tag);
  endtask

  task automatic random_burst(int nbits, int gap_every, string tag);
    int lo, hi, lvl;
    bit b;
    lo = $urandom_range(0, 90);
    hi = clamp8(lo + $urandom_range(30, 160));
    for (int i = 0; i < nbits; i++) begin
      b = $urandom_range(0, 1);
      for (int k = 0; k < 4; k++) begin
        lvl = clamp8((b ? hi : lo) + $urandom_range(0, 8) - 4);
        if (gap_every != 0 && ((i*4 + k) % gap_every) == 0)
          cyc(1'b0, $urandom_range(0, 255), 1'b0, "R7 idle gap");
        cyc(1'b1, lvl, 1'b0, tag);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1; clear = 1'b0; smp_valid = 1'b0; smp_data = 8'd0; min_swing = 8'd20;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state");

    // R2: jump up on first high sample; R4/R3 on following low sample
    cyc(1'b1, 200, 1'b0, "R2 peak jump");
    cyc(1'b1, 40, 1'b0, "R2 floor jump R3 decay");
    cyc(1'b1, 120, 1'b0, "R3 R4 decay both");
    cyc(1'b1, 120, 1'b0, "R5 midpoint");

    // R7: idle cycles with junk data
    for (int i = 0; i < 5; i++) cyc(1'b0, 255 - i*50, 1'b0, "R7 invalid ignored");

    // R10: clear with valid asserted
    cyc(1'b1, 250, 1'b1, "R10 clear");

    // R3: isolated one after a long low run
    for (int i = 0; i < 20; i++) cyc(1'b1, (i % 2) ? 180 : 30, 1'b0, "R8 preamble");
    for (int i = 0; i < 40; i++) cyc(1'b1, 30, 1'b0, "R3 low run");
    cyc(1'b1, 180, 1'b0, "R3 isolated one");
    cyc(1'b1, 30, 1'b0, "R6 back to zero");

    // R6: samples inside the hysteresis band hold the bit
    for (int i = 0; i < 8; i++) cyc(1'b1, (i % 2) ? 200 : 20, 1'b0, "R6 swing");
    cyc(1'b1, (m_pk + m_fl) >> 5, 1'b0, "R6 band hold");
    cyc(1'b1, ((m_pk + m_fl) >> 5) + 1, 1'b0, "R6 band hold");

    // R8/R9: never settles with a huge minimum, then settles and sticks
    cyc(1'b0, 0, 1'b1, "R10 clear");
    min_swing = 8'd255;
    for (int i = 0; i < 30; i++) cyc(1'b1, (i % 2) ? 250 : 5, 1'b0, "R8 no settle");
    cyc(1'b0, 0, 1'b1, "R10 clear");
    min_swing = 8'd40;
    for (int i = 0; i < 24; i++) cyc(1'b1, (i % 2) ? 220 : 10, 1'b0, "R8 settle run");
    for (int i = 0; i < 10; i++) cyc(1'b1, 100, 1'b0, "R9 sticky");

    // random bursts at several minimum swings
    for (int r = 0; r < 12; r++) begin
      cyc(1'b0, 0, 1'b1, "R10 clear");
      case (r % 4)
        0: min_swing = 8'd0;
        1: min_swing = 8'd20;
        2: min_swing = 8'd40;
        default: min_swing = 8'd255;
      endcase
      random_burst(40, (r % 3) * 5 + 3, "R6 random slice");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule